// File: doc/BRIEF.md
# Outbound Address Translation Table

This block turns the addresses of outbound processor requests into bus addresses for a PCIe link. It holds eight programmable windows. Each window has an enable, a 64-bit source base, a power-of-two size, a 64-bit translated base, a 4-bit address-space id and a 3-bit TLP type code. Software programs the windows through a small register port. The request path then sends one address per cycle into the lookup port and gets back the translated address and that window's attributes one cycle later.

Matching is a parallel compare against every enabled window. The bits at and above the size boundary of the window decide the match. When several windows match, the lowest-numbered one wins. On a hit, the output address is built from two parts: the translated base bits above the boundary, and the request bits below it. When nothing matches, a miss is reported and the address comes out unchanged.

Two small state machines run the block. The register read machine has the states RD_IDLE and RD_DATA. It moves RD_IDLE→RD_DATA on a read strobe, stays in RD_DATA while strobes continue, and returns RD_DATA→RD_IDLE when they stop. The lookup machine has the states LK_IDLE and LK_RESP. It moves LK_IDLE→LK_RESP on a request, stays in LK_RESP while requests continue, and returns LK_RESP→LK_IDLE when they stop.

Top module: `outbound_xlate`

## Requirements
- R1: A synchronous active-high reset clears every window register to zero, which disables all windows. It also drives rsp_valid and reg_rvalid low in the cycle after a reset edge.
- R2: Window n occupies the register addresses from 0x800+0x20*n upward. Its words are: source-low at +0x0, source-high at +0x4, translated-low at +0x8, translated-high at +0xC and attributes at +0x10. Every word reads back what was written, except the attribute word, which keeps only bits 3:0 (space id) and bits 18:16 (TLP type) and reads zero elsewhere.
- R3: A read strobe returns its data with reg_rvalid high in the next cycle. Offsets +0x14 to +0x1C inside a window, and addresses outside the table, read zero, and writes to them change no window.
- R4: Bit 0 of source-low enables a window. A disabled window never matches.
- R5: Bits 6:1 of source-low hold f, and the window spans 2^(f+1) bytes. An address matches when its bits 63:f+1 equal the same bits of the source base. The source base is {source-high, source-low[31:7], 7'b0}, so base bits below the boundary play no part in matching.
- R6: On a hit, rsp_addr takes the translated base bits at and above f+1 and the request address bits below f+1.
- R7: When several enabled windows match, the lowest-numbered window supplies rsp_win, rsp_addr and the attributes.
- R8: On a miss, rsp_miss=1, rsp_hit=0, rsp_addr equals the request address, and rsp_win, rsp_tlp and rsp_space are zero. Every response has exactly one of rsp_hit and rsp_miss set.
- R9: rsp_valid is high in the cycle after a cycle with req_valid high, and low otherwise. The response fields hold their values while no request arrives.
- R10: On a hit, rsp_tlp and rsp_space carry bits 18:16 and bits 3:0 of the winning window's attribute word.
- R11: f=63 makes a window cover the full 64-bit space. Every address then matches it and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | REG_AW | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rvalid | output | 1 | Read data valid |
| reg_rdata | output | 32 | Read data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 64 | Processor-side address |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | A window matched |
| rsp_miss | output | 1 | No window matched |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_win | output | IDX_W | Index of the winning window |
| rsp_tlp | output | 3 | TLP type code of the winner |
| rsp_space | output | 4 | Address-space id of the winner |

## Verification
The checker watches, on every cycle:
- the one-cycle timing of the lookup and read handshakes;
- hit and miss being mutually exclusive;
- a miss passing the address through with zeroed attributes;
- response fields holding still between requests.

Only the bench scenarios can show the window arithmetic itself. This covers:
- boundaries of each size, including the two-byte and full-space windows;
- base bits below the boundary being ignored;
- priority among overlapping windows;
- register layout and attribute masking;
- which window a given address lands in.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

    localparam int XLT_AW = 64;
    localparam int XLT_DW = 32;

    // word offsets inside one window
    localparam int OFF_SRC_LO = 'h00;
    localparam int OFF_SRC_HI = 'h04;
    localparam int OFF_DST_LO = 'h08;
    localparam int OFF_DST_HI = 'h0C;
    localparam int OFF_ATTR   = 'h10;

    // source-low word layout
    localparam int EN_BIT   = 0;
    localparam int LG_LSB   = 1;
    localparam int LG_W     = 6;
    localparam int BASE_LSB = LG_LSB + LG_W;

    // attribute word layout
    localparam int SPACE_LSB = 0;
    localparam int SPACE_W   = 4;
    localparam int TLP_LSB   = 16;
    localparam int TLP_W     = 3;

    typedef struct packed {
        logic                 en;
        logic [LG_W-1:0]      lg;
        logic [XLT_AW-1:0]    src;
        logic [XLT_AW-1:0]    dst;
        logic [SPACE_W-1:0]   space;
        logic [TLP_W-1:0]     tlp;
    } xlt_win_t;

    typedef enum logic [0:0] {RD_IDLE, RD_DATA} rd_state_e;
    typedef enum logic [0:0] {LK_IDLE, LK_RESP} lk_state_e;

    // bit b is set when b lies at or above the boundary lg+1
    function automatic logic [XLT_AW-1:0] xlt_hi_mask(input logic [LG_W-1:0] lg);
        logic [XLT_AW-1:0] m;
        for (int b = 0; b < XLT_AW; b++) begin
            m[b] = (b > int'(lg));
        end
        return m;
    endfunction

endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
    import xlt_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int REG_AW     = 12,
    parameter int WIN_BASE   = 'h800,
    parameter int WIN_STRIDE = 'h20,
    localparam int IDX_W     = $clog2(NUM_WIN),
    localparam int WORD_W    = $clog2(WIN_STRIDE),
    localparam int SPAN      = NUM_WIN * WIN_STRIDE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic               rd,
    input  logic [REG_AW-1:0]  addr,
    input  logic [XLT_DW-1:0]  wdata,
    output logic               rvalid,
    output logic [XLT_DW-1:0]  rdata,
    output xlt_win_t           win [NUM_WIN]
);

    logic [REG_AW-1:0]  off;
    logic               in_range;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  word;
    logic [XLT_DW-1:0]  rv [NUM_WIN];
    logic [XLT_DW-1:0]  rd_sel;
    logic [XLT_DW-1:0]  rdata_q;
    rd_state_e          st_q, st_d;

    assign off      = addr - REG_AW'(WIN_BASE);
    assign in_range = (addr >= REG_AW'(WIN_BASE)) && (off < REG_AW'(SPAN));
    assign idx      = off[WORD_W +: IDX_W];
    assign word     = off[WORD_W-1:0];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [XLT_DW-1:0]        src_lo, src_hi, dst_lo, dst_hi;
        logic [TLP_W+SPACE_W-1:0] attr;
        logic                     sel;

        assign sel = wr && in_range && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                src_lo <= '0;
                src_hi <= '0;
                dst_lo <= '0;
                dst_hi <= '0;
                attr   <= '0;
            end else if (sel) begin
                unique case (word)
                    WORD_W'(OFF_SRC_LO): src_lo <= wdata;
                    WORD_W'(OFF_SRC_HI): src_hi <= wdata;
                    WORD_W'(OFF_DST_LO): dst_lo <= wdata;
                    WORD_W'(OFF_DST_HI): dst_hi <= wdata;
                    WORD_W'(OFF_ATTR):   attr   <= {wdata[TLP_LSB +: TLP_W],
                                                    wdata[SPACE_LSB +: SPACE_W]};
                    default: ;
                endcase
            end
        end

        always_comb begin
            rv[g] = '0;
            unique case (word)
                WORD_W'(OFF_SRC_LO): rv[g] = src_lo;
                WORD_W'(OFF_SRC_HI): rv[g] = src_hi;
                WORD_W'(OFF_DST_LO): rv[g] = dst_lo;
                WORD_W'(OFF_DST_HI): rv[g] = dst_hi;
                WORD_W'(OFF_ATTR): begin
                    rv[g][TLP_LSB +: TLP_W]     = attr[SPACE_W +: TLP_W];
                    rv[g][SPACE_LSB +: SPACE_W] = attr[SPACE_W-1:0];
                end
                default: rv[g] = '0;
            endcase
        end

        assign win[g].en    = src_lo[EN_BIT];
        assign win[g].lg    = src_lo[LG_LSB +: LG_W];
        assign win[g].src   = {src_hi, src_lo[XLT_DW-1:BASE_LSB], {BASE_LSB{1'b0}}};
        assign win[g].dst   = {dst_hi, dst_lo};
        assign win[g].space = attr[SPACE_W-1:0];
        assign win[g].tlp   = attr[SPACE_W +: TLP_W];
    end

    assign rd_sel = in_range ? rv[idx] : '0;

    // read state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= RD_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (rd) st_d = RD_DATA;
            RD_DATA: if (!rd) st_d = RD_IDLE;
            default: st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata_q <= '0;
        else if (rd) rdata_q <= rd_sel;
    end

    // outputs
    always_comb begin
        rvalid = (st_q == RD_DATA);
        rdata  = rvalid ? rdata_q : '0;
    end

endmodule

// File: rtl/xlt_match.sv
module xlt_match
    import xlt_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  xlt_win_t           win [NUM_WIN],
    input  logic [XLT_AW-1:0]  addr,
    output logic               hit,
    output logic [IDX_W-1:0]   sel,
    output logic [XLT_AW-1:0]  xaddr,
    output logic [TLP_W-1:0]   tlp,
    output logic [SPACE_W-1:0] space
);

    logic [NUM_WIN-1:0] match;
    logic [XLT_AW-1:0]  cand [NUM_WIN];

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
        logic [XLT_AW-1:0] hm;
        assign hm       = xlt_hi_mask(win[g].lg);
        assign match[g] = win[g].en && (((addr ^ win[g].src) & hm) == '0);
        assign cand[g]  = (win[g].dst & hm) | (addr & ~hm);
    end

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (hit) begin
            xaddr = cand[sel];
            tlp   = win[sel].tlp;
            space = win[sel].space;
        end else begin
            xaddr = addr;
            tlp   = '0;
            space = '0;
        end
    end

endmodule

// File: rtl/outbound_xlate.sv
module outbound_xlate
    import xlt_pkg::*;
#(
    parameter int NUM_WIN    = 8,
    parameter int REG_AW     = 12,
    parameter int WIN_BASE   = 'h800,
    parameter int WIN_STRIDE = 'h20,
    localparam int IDX_W     = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic               reg_rvalid,
    output logic [31:0]        reg_rdata,
    input  logic               req_valid,
    input  logic [63:0]        req_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic               rsp_miss,
    output logic [63:0]        rsp_addr,
    output logic [IDX_W-1:0]   rsp_win,
    output logic [2:0]         rsp_tlp,
    output logic [3:0]         rsp_space
);

    xlt_win_t            win [NUM_WIN];
    logic                m_hit;
    logic [IDX_W-1:0]    m_sel;
    logic [XLT_AW-1:0]   m_addr;
    logic [TLP_W-1:0]    m_tlp;
    logic [SPACE_W-1:0]  m_space;

    lk_state_e           lk_q, lk_d;
    logic                hit_q;
    logic [IDX_W-1:0]    win_q;
    logic [XLT_AW-1:0]   addr_q;
    logic [TLP_W-1:0]    tlp_q;
    logic [SPACE_W-1:0]  space_q;

    xlt_regs #(
        .NUM_WIN    (NUM_WIN),
        .REG_AW     (REG_AW),
        .WIN_BASE   (WIN_BASE),
        .WIN_STRIDE (WIN_STRIDE)
    ) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (reg_wr),
        .rd     (reg_rd),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rvalid (reg_rvalid),
        .rdata  (reg_rdata),
        .win    (win)
    );

    xlt_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win   (win),
        .addr  (req_addr),
        .hit   (m_hit),
        .sel   (m_sel),
        .xaddr (m_addr),
        .tlp   (m_tlp),
        .space (m_space)
    );

    // lookup state register
    always_ff @(posedge clk) begin
        if (rst) lk_q <= LK_IDLE;
        else     lk_q <= lk_d;
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_IDLE: if (req_valid) lk_d = LK_RESP;
            LK_RESP: if (!req_valid) lk_d = LK_IDLE;
            default: lk_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q   <= 1'b0;
            win_q   <= '0;
            addr_q  <= '0;
            tlp_q   <= '0;
            space_q <= '0;
        end else if (req_valid) begin
            hit_q   <= m_hit;
            win_q   <= m_sel;
            addr_q  <= m_addr;
            tlp_q   <= m_tlp;
            space_q <= m_space;
        end
    end

    // outputs
    always_comb begin
        rsp_valid = (lk_q == LK_RESP);
        rsp_hit   = rsp_valid && hit_q;
        rsp_miss  = rsp_valid && !hit_q;
        rsp_addr  = addr_q;
        rsp_win   = win_q;
        rsp_tlp   = tlp_q;
        rsp_space = space_q;
    end

endmodule

// File: rtl/outbound_xlate_chk.sv
module outbound_xlate_chk #(
    parameter int IDX_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic              reg_rvalid,
    input logic              req_valid,
    input logic [63:0]       req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic              rsp_miss,
    input logic [63:0]       rsp_addr,
    input logic [IDX_W-1:0]  rsp_win,
    input logic [2:0]        rsp_tlp,
    input logic [3:0]        rsp_space
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!rsp_valid && !reg_rvalid));

    // R3
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> reg_rvalid);

    // R3
    read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> !reg_rvalid);

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R9
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_addr) && $stable(rsp_win)));

    // R8
    hit_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit != rsp_miss));

    // R8
    miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_addr == $past(req_addr)));

    // R8
    miss_attr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_miss) |-> (rsp_tlp == 3'd0 && rsp_space == 4'd0
                                     && rsp_win == '0));

endmodule

bind outbound_xlate outbound_xlate_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_rd     (reg_rd),
    .reg_rvalid (reg_rvalid),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_miss   (rsp_miss),
    .rsp_addr   (rsp_addr),
    .rsp_win    (rsp_win),
    .rsp_tlp    (rsp_tlp),
    .rsp_space  (rsp_space)
);

// File: tb/sim_outbound_xlate.sv
`timescale 1ns/1ps
module sim_outbound_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rvalid;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_miss;
    logic [63:0] rsp_addr;
    logic [2:0]  rsp_win;
    logic [2:0]  rsp_tlp;
    logic [3:0]  rsp_space;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    outbound_xlate u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_addr(rsp_addr), .rsp_win(rsp_win), .rsp_tlp(rsp_tlp),
        .rsp_space(rsp_space)
    );

    typedef struct packed {
        logic [63:0] a;
        logic        hit;
        logic [63:0] x;
        logic [2:0]  w;
        logic [2:0]  t;
        logic [3:0]  s;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{64'h0000_0001_2000_0000, 1'b1, 64'h0000_0000_8000_0000, 3'd1, 3'd0, 4'd0}, // R5 R6 low edge
        '{64'h0000_0001_200F_FFFF, 1'b1, 64'h0000_0000_800F_FFFF, 3'd1, 3'd0, 4'd0}, // R5 R6 high edge
        '{64'h0000_0001_2010_0000, 1'b0, 64'h0000_0001_2010_0000, 3'd0, 3'd0, 4'd0}, // R8 just past
        '{64'h0000_0001_2004_0123, 1'b1, 64'h0000_0000_8004_0123, 3'd1, 3'd0, 4'd0}, // R7 w1 over w3
        '{64'h0000_0000_4000_ABCD, 1'b1, 64'h0000_0000_0001_ABCD, 3'd2, 3'd2, 4'd1}, // R10 io window
        '{64'h0000_0000_4001_0000, 1'b0, 64'h0000_0000_4001_0000, 3'd0, 3'd0, 4'd0}, // R8
        '{64'h0000_0000_6000_0004, 1'b1, 64'h0000_0000_0070_0004, 3'd5, 3'd0, 4'd0}, // R5 junk base bits
        '{64'h0000_0000_6000_0FFF, 1'b1, 64'h0000_0000_0070_0FFF, 3'd5, 3'd0, 4'd0}, // R5 R6
        '{64'h0000_0000_6000_1000, 1'b0, 64'h0000_0000_6000_1000, 3'd0, 3'd0, 4'd0}, // R8
        '{64'h0000_0000_7000_0081, 1'b1, 64'h0000_0005_0000_0101, 3'd4, 3'd0, 4'd0}, // R5 two-byte
        '{64'h0000_0000_7000_0082, 1'b0, 64'h0000_0000_7000_0082, 3'd0, 3'd0, 4'd0}, // R5 R8
        '{64'h0000_0000_1000_0010, 1'b0, 64'h0000_0000_1000_0010, 3'd0, 3'd0, 4'd0}, // R4 disabled w0
        '{64'h0000_0002_2000_0000, 1'b0, 64'h0000_0002_2000_0000, 3'd0, 3'd0, 4'd0}  // R5 high word
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        chk({req, " rvalid"}, 64'(reg_rvalid), 64'd1);
        chk(req, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic look(input string req, input logic [63:0] a, input logic hit,
                        input logic [63:0] x, input logic [2:0] w,
                        input logic [2:0] t, input logic [3:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({req, " valid"}, 64'(rsp_valid), 64'd1);
        chk({req, " hit"}, {62'd0, rsp_hit, rsp_miss}, {62'd0, hit, !hit});
        chk({req, " addr"}, rsp_addr, x);
        chk({req, " win/tlp/space"}, {54'd0, rsp_win, rsp_tlp, rsp_space}, {54'd0, w, t, s});
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 rvalid", 64'(reg_rvalid), 64'd0);
        rst = 1'b0;
        rd_chk("R1 cleared src", 12'h820, 32'h0);
        look("R1 all disabled", 64'h0000_0001_2000_0000, 1'b0, 64'h0000_0001_2000_0000, 3'd0, 3'd0, 4'd0);

        // program windows
        wr(12'h800, 32'h1000_0016); wr(12'h808, 32'h0000_3000);
        wr(12'h820, 32'h2000_0027); wr(12'h824, 32'h1); wr(12'h828, 32'h8000_0000);
        wr(12'h840, 32'h4000_001F); wr(12'h848, 32'h0001_0000); wr(12'h850, 32'h0002_0001);
        wr(12'h860, 32'h2004_0017); wr(12'h864, 32'h1); wr(12'h86C, 32'h0000_0DEA);
        wr(12'h880, 32'h7000_0081); wr(12'h888, 32'h0000_0100); wr(12'h88C, 32'h5);
        wr(12'h8A0, 32'h6000_0F97); wr(12'h8A8, 32'h0070_0ABC);

        // R2 readback and attribute masking
        rd_chk("R2 src lo", 12'h820, 32'h2000_0027);
        rd_chk("R2 dst hi", 12'h86C, 32'h0000_0DEA);
        rd_chk("R2 attr", 12'h850, 32'h0002_0001);
        wr(12'h8D0, 32'hFFFF_FFFF);
        rd_chk("R2 attr mask", 12'h8D0, 32'h0007_000F);
        // R3 unmapped
        wr(12'h834, 32'h1234_5678);
        rd_chk("R3 gap offset", 12'h834, 32'h0);
        rd_chk("R3 below table", 12'h7FC, 32'h0);
        rd_chk("R3 above table", 12'h900, 32'h0);
        rd_chk("R3 window intact", 12'h830, 32'h0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            look($sformatf("vec%0d", i), VT[i].a, VT[i].hit, VT[i].x, VT[i].w, VT[i].t, VT[i].s);
        end

        // R11 full-space window
        wr(12'h8E0, 32'h0000_007F);
        look("R11 far addr", 64'h0000_0002_2000_0000, 1'b1, 64'h0000_0002_2000_0000, 3'd7, 3'd0, 4'd0);
        look("R11 top addr", 64'hFFFF_FFFF_FFFF_FFF0, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 3'd7, 3'd0, 4'd0);
        // R4 disable w1, w3 now wins
        wr(12'h820, 32'h2000_0026);
        look("R4 R7 w3 after w1 off", 64'h0000_0001_2004_0123, 1'b1, 64'h0000_0DEA_0000_0123, 3'd3, 3'd0, 4'd0);
        // R7 enable w0, beats w7
        wr(12'h800, 32'h1000_0017);
        look("R7 w0 over w7", 64'h0000_0000_1000_0010, 1'b1, 64'h0000_0000_0000_3010, 3'd0, 3'd0, 4'd0);

        // R9 response stays low without request
        @(negedge clk);
        chk("R9 idle", 64'(rsp_valid), 64'd0);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_chk("R1 after reset", 12'h800, 32'h0);
        look("R1 miss after reset", 64'h0000_0000_1000_0010, 1'b0, 64'h0000_0000_1000_0010, 3'd0, 3'd0, 4'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule